// File: doc/BRIEF.md
# Byte-Stepped I2C Bus Master

This block is an I2C bus master that software steps through a transfer one byte at a time. It has three 32-bit registers. One holds the byte to send or the byte received. One holds the command and configuration bits. One holds status flags that software clears by writing ones. Each command moves exactly one byte plus its acknowledge bit. A command may also put a START (or repeated START) in front of the byte and a STOP after the acknowledge. The master can also answer a received byte with NACK instead of ACK.

The address phase is an ordinary transmitted byte. Software loads the 7-bit address, shifted left by one, into the data register. Bit 0 of that first byte after a START sets the direction of every later byte up to the next START: 1 means the slave sends, 0 means the master sends. SCL and SDA are open-drain. The block only pulls a line low, through an output-enable. SCL timing comes from a quarter-period tick generator. The tick interval is the parameter `QTR_STD` in standard mode and `QTR_FAST` in fast mode.

Top module: `i2cm_byte_master`

## Requirements
- R1: Register byte offsets are 0x4 for data, 0x8 for control and 0xC for status; any other offset reads zero. Control bits 0 (START), 1 (STOP), 2 (NAK), 5 (master enable), 6 (unit enable), 7 (general-call disable), 14 (unit reset) and 17:16 (speed) read back as written; bit 3 (TX_BYTE) reads back as described in R2. After reset every register reads zero and both output-enables are low.
- R2: Writing control bit 3 (TX_BYTE) as 1 while it reads 0 launches one byte phase. START, STOP and NAK are taken from that same write. TX_BYTE reads 1 while the byte is in progress and returns to 0 by itself when the byte completes.
- R3: With START in the launch write, the master produces SDA falling while SCL is high before the byte. Status bit 3 (bus busy) goes to 1 at that point and stays 1 while the bus is held between bytes.
- R4: A byte the master sends goes out MSB first. Status bit 6 (TXE) sets once the byte and its acknowledge bit are done. Status bit 1 (NACK seen) sets if the slave left SDA high in the acknowledge bit.
- R5: Once the first byte after a START has bit 0 = 1, later bytes are received: the byte shifted in MSB first appears in the data register and status bit 7 (RXF) sets.
- R6: On a received byte, the master pulls SDA low in the acknowledge bit when control bit 2 (NAK) was 0 at launch, and leaves it released when NAK was 1.
- R7: With STOP in the launch write, SDA rises while SCL is high after the acknowledge bit, and bus busy returns to 0.
- R8: Writing 1 to status bits 1, 6 or 7 clears only those bits; writing 0x7FF clears them all; a flag that sets in the same cycle stays set.
- R9: While control bit 14 (unit reset) is 1 or bit 6 (unit enable) is 0, any byte phase is abandoned, both lines are released, the busy bits read 0, and a TX_BYTE write is not taken (bit 3 reads 0).
- R10: A TX_BYTE write without START while the master does not hold the bus is not taken: bit 3 reads 0, SCL never moves, and no status flag sets.
- R11: Each SCL high and low half lasts two quarter ticks; a quarter is `QTR_STD` clock cycles, or `QTR_FAST` cycles when control bits 17:16 are 01. SDA changes only while SCL is low, except in START and STOP.
- R12: Status bit 2 (unit busy) reads 1 from the launch until the byte phase and any STOP complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from the offset |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A wrong bit counter or phase counter inside the byte engine shows up on the pins within one SCL period. It appears as an SDA change while SCL is high, an acknowledge sampled on the wrong clock, or a byte that the slave model logs shifted by one place. A stuck direction flag after the address byte shows as a wrong data-register value on the very next received byte. A missing self-clear of the launch bit shows one register read after TXE or RXF. Lost bus-busy or unit-busy state is visible at the status register as soon as a START or STOP completes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   // control register bit positions
   localparam int CB_START = 0;
   localparam int CB_STOP  = 1;
   localparam int CB_NAK   = 2;
   localparam int CB_TXB   = 3;
   localparam int CB_MEN   = 5;
   localparam int CB_EN    = 6;
   localparam int CB_GCD   = 7;
   localparam int CB_RST   = 14;
   localparam int CB_SPD   = 16;
   // status register bit positions
   localparam int SB_NAK   = 1;
   localparam int SB_UBUSY = 2;
   localparam int SB_BBUSY = 3;
   localparam int SB_TXE   = 6;
   localparam int SB_RXF   = 7;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_START,
      ENG_BIT,
      ENG_HOLD,
      ENG_STOP
   } eng_st_e;

   typedef struct packed {
      logic       start;
      logic       stop;
      logic       nak;
      logic [7:0] data;
   } byte_cmd_t;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
   parameter int QTR_STD  = 250,
   parameter int QTR_FAST = 63
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast,
   output logic tick
);
   localparam int QMAX  = (QTR_STD > QTR_FAST) ? QTR_STD : QTR_FAST;
   localparam int CNT_W = $clog2(QMAX) + 1;

   initial begin
      assert (QTR_STD >= 2) else $error("QTR_STD must be at least 2");
      assert (QTR_FAST >= 2) else $error("QTR_FAST must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim_m1;

   generate
      if (QTR_STD == QTR_FAST) begin : g_single
         assign lim_m1 = CNT_W'(QTR_STD - 1);
      end else begin : g_dual
         logic unused_fast;
         assign unused_fast = 1'b0;
         assign lim_m1 = fast ? CNT_W'(QTR_FAST - 1) : CNT_W'(QTR_STD - 1);
      end
   endgenerate

   generate
      if (QTR_STD == QTR_FAST) begin : g_unused
         logic unused_sel;
         assign unused_sel = fast;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (cnt >= lim_m1)  cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt >= lim_m1);

   // quarter ticks never come back to back (R11)
   p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
   import i2cm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      tick,
   input  logic      go,
   input  byte_cmd_t cmd,
   input  logic      sda_in,
   output logic      scl_drv,
   output logic      sda_drv,
   output logic      done,
   output logic      done_rx,
   output logic      done_nak,
   output logic [7:0] rx_byte,
   output logic      bus_busy,
   output logic      unit_busy,
   output logic      owned
);
   eng_st_e    st;
   logic [1:0] q;
   logic [3:0] bitn;
   logic [7:0] sh;
   byte_cmd_t  cmd_q;
   logic       rd_mode;
   logic       addr_ph;
   logic       ack_smp;
   logic       rx_cur;

   assign rx_cur    = rd_mode && !addr_ph;
   assign unit_busy = (st == ENG_START) || (st == ENG_BIT) || (st == ENG_STOP);
   assign owned     = (st == ENG_HOLD);
   assign rx_byte   = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ENG_IDLE; q <= '0; bitn <= '0; sh <= '0; cmd_q <= '0;
         rd_mode <= 1'b0; addr_ph <= 1'b0; ack_smp <= 1'b0;
         scl_drv <= 1'b0; sda_drv <= 1'b0; bus_busy <= 1'b0;
         done <= 1'b0; done_rx <= 1'b0; done_nak <= 1'b0;
      end else if (clr) begin
         st <= ENG_IDLE; q <= '0; bitn <= '0;
         rd_mode <= 1'b0; addr_ph <= 1'b0;
         scl_drv <= 1'b0; sda_drv <= 1'b0; bus_busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && (st == ENG_IDLE || st == ENG_HOLD)) begin
            cmd_q <= cmd;
            sh    <= cmd.data;
            q     <= '0;
            bitn  <= '0;
            if (cmd.start) begin
               st      <= ENG_START;
               addr_ph <= 1'b1;
            end else begin
               st <= ENG_BIT;
            end
         end else if (tick) begin
            q <= q + 2'd1;
            unique case (st)
               ENG_START: begin
                  unique case (q)
                     2'd0: sda_drv <= 1'b0;
                     2'd1: scl_drv <= 1'b0;
                     2'd2: begin sda_drv <= 1'b1; bus_busy <= 1'b1; end
                     default: begin scl_drv <= 1'b1; st <= ENG_BIT; end
                  endcase
               end
               ENG_BIT: begin
                  unique case (q)
                     2'd0: begin
                        if (bitn < 4'd8) sda_drv <= rx_cur ? 1'b0 : ~sh[7];
                        else             sda_drv <= rx_cur ? ~cmd_q.nak : 1'b0;
                     end
                     2'd1: scl_drv <= 1'b0;
                     2'd2: begin
                        if (bitn < 4'd8) sh <= {sh[6:0], sda_in};
                        else             ack_smp <= sda_in;
                     end
                     default: begin
                        scl_drv <= 1'b1;
                        if (bitn == 4'd8) begin
                           done     <= 1'b1;
                           done_rx  <= rx_cur;
                           done_nak <= ack_smp;
                           bitn     <= '0;
                           if (addr_ph) begin
                              rd_mode <= cmd_q.data[0];
                              addr_ph <= 1'b0;
                           end
                           st <= cmd_q.stop ? ENG_STOP : ENG_HOLD;
                        end else begin
                           bitn <= bitn + 4'd1;
                        end
                     end
                  endcase
               end
               ENG_STOP: begin
                  unique case (q)
                     2'd0: sda_drv <= 1'b1;
                     2'd1: scl_drv <= 1'b0;
                     2'd2: begin sda_drv <= 1'b0; bus_busy <= 1'b0; end
                     default: begin st <= ENG_IDLE; rd_mode <= 1'b0; end
                  endcase
               end
               default: q <= '0;
            endcase
         end
      end
   end

   // SDA holds still across a high SCL inside a data or acknowledge bit (R11)
   p_sda_hi_stable_r11: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (st == ENG_BIT && $past(st) == ENG_BIT && !scl_drv && !$past(scl_drv))
      |-> $stable(sda_drv));

   // bus busy rises only as SDA falls under a high SCL (R3)
   p_start_scl_hi_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
      $rose(bus_busy) |-> (!scl_drv && sda_drv));

   // bus busy falls only with both lines released (R7)
   p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_busy) && !$past(clr)) |-> (!scl_drv && !sda_drv));

   // a clear request leaves the lines free and the bus idle (R9)
   p_clr_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!scl_drv && !sda_drv && !bus_busy && !unit_busy));
endmodule

// File: rtl/i2cm_byte_master.sv
module i2cm_byte_master
   import i2cm_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int REG_W    = 32,
   parameter int QTR_STD  = 250,
   parameter int QTR_FAST = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe
);
   localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(12);
   localparam logic [1:0]        SPD_FAST = 2'b01;

   initial begin
      assert (ADDR_W >= 4) else $error("ADDR_W too small for the register map");
      assert (REG_W >= 18) else $error("REG_W too small for the control fields");
   end

   // control fields
   logic       c_start, c_stop, c_nak, c_txb, c_men, c_en, c_gcd, c_rst;
   logic [1:0] c_spd;
   // status flags
   logic       s_nak, s_txe, s_rxf;
   logic [7:0] data_q;

   logic       ctrl_wr, stat_wr, data_wr, launch, eng_clr;
   logic       tick, e_done, e_done_rx, e_done_nak, e_bbusy, e_ubusy, e_owned;
   logic [7:0] e_rx;
   byte_cmd_t  e_cmd;
   logic       unused_w;

   assign ctrl_wr = reg_we && (reg_addr == OFF_CTRL);
   assign stat_wr = reg_we && (reg_addr == OFF_STAT);
   assign data_wr = reg_we && (reg_addr == OFF_DATA);
   assign eng_clr = c_rst || !c_en;
   assign unused_w = ^{reg_wdata[REG_W-1:18], reg_wdata[15], reg_wdata[13:8]};

   // a byte phase starts only on a 0->1 TX_BYTE write with the unit on (R2, R9, R10)
   assign launch = ctrl_wr && reg_wdata[CB_TXB] && !c_txb
                && c_en && !c_rst && reg_wdata[CB_EN] && !reg_wdata[CB_RST]
                && !e_ubusy && (reg_wdata[CB_START] || e_owned);

   assign e_cmd = '{start: reg_wdata[CB_START], stop: reg_wdata[CB_STOP],
                    nak: reg_wdata[CB_NAK], data: data_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_start <= 1'b0; c_stop <= 1'b0; c_nak <= 1'b0; c_men <= 1'b0;
         c_en <= 1'b0; c_gcd <= 1'b0; c_rst <= 1'b0; c_spd <= '0;
      end else if (ctrl_wr) begin
         c_start <= reg_wdata[CB_START];
         c_stop  <= reg_wdata[CB_STOP];
         c_nak   <= reg_wdata[CB_NAK];
         c_men   <= reg_wdata[CB_MEN];
         c_en    <= reg_wdata[CB_EN];
         c_gcd   <= reg_wdata[CB_GCD];
         c_rst   <= reg_wdata[CB_RST];
         c_spd   <= reg_wdata[CB_SPD+1:CB_SPD];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 c_txb <= 1'b0;
      else if (eng_clr || e_done) c_txb <= 1'b0;
      else if (launch)            c_txb <= 1'b1;
   end

   // status: write-one-to-clear, a new event wins over the clear (R8)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_nak <= 1'b0; s_txe <= 1'b0; s_rxf <= 1'b0;
      end else begin
         if (stat_wr) begin
            if (reg_wdata[SB_NAK]) s_nak <= 1'b0;
            if (reg_wdata[SB_TXE]) s_txe <= 1'b0;
            if (reg_wdata[SB_RXF]) s_rxf <= 1'b0;
         end
         if (e_done) begin
            if (e_done_rx) s_rxf <= 1'b1;
            else begin
               s_txe <= 1'b1;
               if (e_done_nak) s_nak <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     data_q <= '0;
      else if (e_done && e_done_rx)   data_q <= e_rx;
      else if (data_wr)               data_q <= reg_wdata[7:0];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFF_DATA) begin
         reg_rdata[7:0] = data_q;
      end else if (reg_addr == OFF_CTRL) begin
         reg_rdata[CB_START] = c_start;
         reg_rdata[CB_STOP]  = c_stop;
         reg_rdata[CB_NAK]   = c_nak;
         reg_rdata[CB_TXB]   = c_txb;
         reg_rdata[CB_MEN]   = c_men;
         reg_rdata[CB_EN]    = c_en;
         reg_rdata[CB_GCD]   = c_gcd;
         reg_rdata[CB_RST]   = c_rst;
         reg_rdata[CB_SPD+1:CB_SPD] = c_spd;
      end else if (reg_addr == OFF_STAT) begin
         reg_rdata[SB_NAK]   = s_nak;
         reg_rdata[SB_UBUSY] = e_ubusy;
         reg_rdata[SB_BBUSY] = e_bbusy;
         reg_rdata[SB_TXE]   = s_txe;
         reg_rdata[SB_RXF]   = s_rxf;
      end
   end

   i2cm_qtick #(.QTR_STD(QTR_STD), .QTR_FAST(QTR_FAST)) u_qtick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (e_ubusy && !eng_clr),
      .fast (c_spd == SPD_FAST),
      .tick (tick)
   );

   i2cm_engine u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (eng_clr),
      .tick     (tick),
      .go       (launch),
      .cmd      (e_cmd),
      .sda_in   (sda_in),
      .scl_drv  (scl_oe),
      .sda_drv  (sda_oe),
      .done     (e_done),
      .done_rx  (e_done_rx),
      .done_nak (e_done_nak),
      .rx_byte  (e_rx),
      .bus_busy (e_bbusy),
      .unit_busy(e_ubusy),
      .owned    (e_owned)
   );

   // TX_BYTE falls only at byte completion or on abort (R2)
   p_txb_selfclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(c_txb) |-> ($past(e_done) || $past(eng_clr)));

   // a one written to TXE clears it unless a byte finished at once (R8)
   p_w1c_txe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && reg_wdata[SB_TXE] && !e_done) |=> !s_txe);

   // the unit is busy in the cycle after a launch (R12)
   p_launch_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !eng_clr) |=> e_ubusy);
endmodule

// File: tb/i2cm_byte_master_tb.sv
module i2cm_byte_master_tb;
   localparam int QS = 10;
   localparam int QF = 4;
   localparam logic [3:0] A_DATA = 4'h4, A_CTRL = 4'h8, A_STAT = 4'hC;
   localparam logic [31:0] BASE = 32'h0000_0060;
   localparam logic [31:0] FAST = 32'h0001_0000;
   localparam logic [6:0]  SLV  = 7'h50;
   localparam int NV = 10;
   // {start, stop, nak, isrx, expnak, data[7:0], exp[7:0]}
   localparam logic [20:0] VEC [0:NV-1] = '{
      {5'b10000, 8'hA0, 8'hA0},
      {5'b00000, 8'h3C, 8'h3C},
      {5'b01000, 8'hC3, 8'hC3},
      {5'b10000, 8'hA1, 8'hA1},
      {5'b00010, 8'h00, 8'h96},
      {5'b01110, 8'h00, 8'h97},
      {5'b11001, 8'h44, 8'h44},
      {5'b10000, 8'hA0, 8'hA0},
      {5'b10000, 8'hA1, 8'hA1},
      {5'b01110, 8'h00, 8'h98}
   };

   logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic scl_oe, sda_oe, sda_w, scl_w;
   int nchk = 0, nfail = 0, cyc = 0;

   always #2 clk = ~clk;

   // slave model
   logic slv_low = 1'b0, scl_p = 1'b1, sda_p = 1'b1, first = 1'b0, slv_rd = 1'b0, mack = 1'b0;
   logic [7:0] sh = '0, got = '0, outb = '0, rdv = 8'h96;
   int bc = 0, scl_falls = 0, hi_cnt = 0, last_hi = 0;

   assign scl_w = ~scl_oe;
   assign sda_w = ~(sda_oe | slv_low);

   i2cm_byte_master #(.QTR_STD(QS), .QTR_FAST(QF)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_w),
      .scl_oe(scl_oe), .sda_oe(sda_oe));

   always @(negedge clk) begin
      if (!scl_w) begin
         if (hi_cnt != 0) last_hi = hi_cnt;
         hi_cnt = 0;
      end else hi_cnt = hi_cnt + 1;
      if (scl_p && !scl_w) scl_falls = scl_falls + 1;
      if (!rst_n) begin
         bc = 0; first = 0; slv_rd = 0; slv_low = 0;
      end else if (scl_w && scl_p && sda_p && !sda_w) begin
         bc = 0; first = 1; slv_rd = 0; slv_low = 0;
      end else if (scl_w && scl_p && !sda_p && sda_w) begin
         bc = 0; first = 0; slv_rd = 0; slv_low = 0;
      end else if (!scl_p && scl_w) begin
         if (bc < 8) sh = {sh[6:0], sda_w};
         else mack = sda_w;
         bc = bc + 1;
      end else if (scl_p && !scl_w) begin
         if (bc == 8) begin
            if (!slv_rd) begin
               got = sh;
               slv_low = first ? (sh[7:1] == SLV) : 1'b1;
            end else slv_low = 0;
         end else if (bc == 9) begin
            bc = 0; slv_low = 0;
            if (first) begin
               first = 0;
               slv_rd = got[0] && (got[7:1] == SLV);
            end else if (slv_rd && mack) slv_rd = 0;
            if (slv_rd) begin
               outb = rdv; rdv = rdv + 8'h01; slv_low = ~outb[7];
            end
         end else if (slv_rd && bc >= 1 && bc <= 7) slv_low = ~outb[7-bc];
      end
      scl_p = scl_w; sda_p = sda_w;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.1 d = reg_rdata;
   endtask

   task automatic wait_bit(input int b, input logic v, input string req);
      logic [31:0] s;
      for (int i = 0; i < 4000; i++) begin
         rd(A_STAT, s);
         if (s[b] == v) return;
      end
      check(req, 32'(s[b]), 32'(v));
   endtask

   task automatic op(input logic [31:0] mode, input logic st, input logic sp,
                     input logic nk, input logic [7:0] d);
      logic [31:0] s;
      wr(A_CTRL, mode);
      if (st || !(u_dut.reg_rdata === 32'hx)) wr(A_DATA, {24'h0, d});
      wr(A_CTRL, mode | {28'h0, 1'b1, nk, sp, st});
      rd(A_STAT, s);
      check("R12 unit busy after launch", 32'(s[2]), 32'h1);
      wait_bit(2, 1'b0, "R12 unit busy clears");
   endtask

   logic [31:0] v;
   int e0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state and map
      rd(A_STAT, v); check("R1 status after reset", v, 32'h0);
      rd(A_CTRL, v); check("R1 control after reset", v, 32'h0);
      rd(A_DATA, v); check("R1 data after reset", v, 32'h0);
      check("R1 lines released after reset", {30'h0, scl_oe, sda_oe}, 32'h0);
      wr(A_CTRL, 32'h0001_00E0);
      rd(A_CTRL, v); check("R1 control readback", v, 32'h0001_00E0);
      rd(4'h0, v);   check("R1 unmapped offset", v, 32'h0);
      // R10 no START while bus free
      wr(A_CTRL, BASE);
      e0 = scl_falls;
      wr(A_CTRL, BASE | 32'h8);
      rd(A_CTRL, v); check("R10 TX_BYTE not taken", 32'(v[3]), 32'h0);
      repeat (60) @(negedge clk);
      check("R10 SCL idle", 32'(scl_falls - e0), 32'h0);
      rd(A_STAT, v); check("R10 no status flags", v, 32'h0);
      // R9 disabled unit
      wr(A_DATA, 32'hA0);
      wr(A_CTRL, 32'h0000_0029);
      rd(A_CTRL, v); check("R9 TX_BYTE not taken when disabled", 32'(v[3]), 32'h0);
      repeat (60) @(negedge clk);
      check("R9 SCL idle when disabled", 32'(scl_falls - e0), 32'h0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic st, sp, nk, isrx, xnak;
         logic [7:0] d, x;
         {st, sp, nk, isrx, xnak, d, x} = VEC[i];
         op(BASE, st, sp, nk, d);
         rd(A_CTRL, v); check("R2 TX_BYTE self-clear", 32'(v[3]), 32'h0);
         rd(A_STAT, v);
         if (isrx) begin
            check("R5 RXF set", 32'(v[7]), 32'h1);
            rd(A_DATA, v); check("R5 received byte", v, {24'h0, x});
            check("R6 master acknowledge level", 32'(mack), 32'(nk));
         end else begin
            check("R4 TXE set", 32'(v[6]), 32'h1);
            check("R4 slave NACK flag", 32'(v[1]), 32'(xnak));
            check("R4 byte seen by slave MSB first", 32'(got), 32'(x));
         end
         rd(A_STAT, v);
         if (sp) check("R7 bus free after STOP", 32'(v[3]), 32'h0);
         else    check("R3 bus held busy", 32'(v[3]), 32'h1);
         if (i == 0) check("R11 standard SCL high time", 32'(last_hi), 32'(2 * QS));
         wr(A_STAT, 32'hC2);
      end

      // R8 partial and full clear
      op(BASE, 1'b1, 1'b1, 1'b0, 8'h44);
      wr(A_STAT, 32'h40);
      rd(A_STAT, v); check("R8 partial clear keeps NACK", v & 32'hC2, 32'h02);
      wr(A_STAT, 32'h7FF);
      rd(A_STAT, v); check("R8 clear all", v, 32'h0);

      // R9 abort by unit reset
      wr(A_DATA, 32'hA0);
      wr(A_CTRL, BASE | 32'h9);
      wait_bit(3, 1'b1, "R3 bus busy after START");
      wr(A_CTRL, BASE | 32'h4000);
      @(negedge clk);
      check("R9 lines released on reset", {30'h0, scl_oe, sda_oe}, 32'h0);
      rd(A_STAT, v); check("R9 busy bits cleared", v & 32'hC, 32'h0);
      rd(A_CTRL, v); check("R9 TX_BYTE cleared", 32'(v[3]), 32'h0);
      wr(A_CTRL, BASE);

      // R11 fast mode
      op(BASE | FAST, 1'b1, 1'b1, 1'b0, 8'hA0);
      rd(A_STAT, v); check("R11 fast byte acknowledged", v & 32'h42, 32'h40);
      check("R11 fast SCL high time", 32'(last_hi), 32'(2 * QF));
      check("R4 fast byte at slave", 32'(got), 32'hA0);

      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end
endmodule